// File: doc/BRIEF.md
# Constant-Fraction Sub-Sample Timestamp Refiner

This block refines a coarse event time counted in sample clocks to one thirty-second of a sample period. For each event it receives the coarse count, the position of the trigger sample inside the event window, and a 4-bit fraction setting. It then receives a fixed-length window of normalized samples. It finds the largest sample in the window and derives a threshold equal to the chosen fraction of that peak. It looks for the first pair of neighbouring samples whose values enclose the threshold, and interpolates linearly between the two to find where the crossing falls.

The result is a 29-bit fine timestamp. The upper 24 bits are the coarse count, moved by the offset between the crossing sample and the trigger sample. The lower 5 bits are the interpolated fraction. When no pair in the window encloses the threshold, the coarse count is passed through with a zero fraction and a flag marks the result as not refined. A one-cycle done strobe marks every result. The block takes one event at a time and reports that it is occupied while it holds one.

Top module: `dcfd_ts_refine`

## Requirements
- R1: While reset is held and right after it is released, `done`, `busy` and `invalid` are 0 and `fine_ts` is 0.
- R2: The threshold is floor(P * F / 16), where P is the largest of the WIN (16) samples of the event and F is the value of `frac_sel` captured at `start`.
- R3: The crossing index k is the lowest index in 0..WIN-2 for which s[k] <= threshold and s[k+1] >= threshold. Samples are indexed in the order they are accepted.
- R4: For a found crossing, `fine_ts[28:5]` equals (coarse + k - trig_idx) modulo 2^24, using the values of `coarse_ts` and `trig_idx` captured at `start`.
- R5: For a found crossing with s[k+1] > s[k], `fine_ts[4:0]` equals min(31, floor(32 * (threshold - s[k]) / (s[k+1] - s[k]))).
- R6: For a found crossing with s[k+1] == s[k], `fine_ts[4:0]` is 0.
- R7: When no index satisfies R3, `fine_ts` is {coarse, 5'b0} and `invalid` is 1. For a found crossing, `invalid` is 0.
- R8: `done` is high for exactly one cycle, and the event is no longer busy in that cycle. `done` rises k+7 clock edges after the edge that accepts the last sample when a crossing is found, and WIN-1 edges after it when none is found.
- R9: `start` is acted on only when `busy` is 0, and `busy` rises on the next edge. `start` pulses while busy, and `smp_valid` while idle, have no effect on any result.
- R10: Changes to `coarse_ts`, `trig_idx` and `frac_sel` after the `start` cycle have no effect on the event in progress.
- R11: `fine_ts` and `invalid` keep their values between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an event; captures the coarse count, trigger position and fraction |
| coarse_ts | input | 24 | Coarse event time in sample clocks |
| trig_idx | input | 4 | Window index of the trigger sample |
| frac_sel | input | 4 | Threshold fraction in sixteenths of the peak |
| smp_valid | input | 1 | A window sample is present on `smp_data` |
| smp_data | input | 8 | Normalized sample value, unsigned |
| busy | output | 1 | An event is being loaded or processed |
| done | output | 1 | One-cycle strobe: a new result is on `fine_ts` and `invalid` |
| invalid | output | 1 | The last result had no threshold crossing |
| fine_ts | output | 29 | Coarse count (bits 28:5) and interpolated fraction (bits 4:0) |

## Verification
The block produces no result until it has seen all WIN samples of an event. The delay to the result then depends on where the crossing lies: k+7 edges after the last sample when a pair is found, because of one scan step per index plus the five division steps and the output register, and WIN-1 edges when none is found. After the last sample the bench counts clock edges and samples `done` at the falling edge after each rising edge. It compares the count with the delay predicted from its own search for the crossing, which also confirms the index that was found. It reads the timestamp and the flag in the same half-cycle, then checks one falling edge later that the strobe has dropped.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;

    // Controller phases of one event
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for start
        PH_FILL = 2'd1,   // accepting window samples, tracking peak
        PH_SEEK = 2'd2,   // one adjacent pair tested per cycle
        PH_DIVW = 2'd3    // waiting for the fraction divider
    } phase_t;

endpackage

// File: rtl/dcfd_sample_buf.sv
// Window store: one register per sample slot, one write port, and two read
// ports that return a slot and its upper neighbour.
module dcfd_sample_buf #(
    parameter int WIN = 16,
    parameter int SW  = 8,
    localparam int IDXW = $clog2(WIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [SW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [SW-1:0]   rd_lo,
    output logic [SW-1:0]   rd_hi
);
    logic [SW-1:0] slot_q [WIN];
    logic [SW-1:0] slot_d [WIN];

    for (genvar g = 0; g < WIN; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDXW'(g))) begin
                slot_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    logic [IDXW-1:0] rd_nxt;

    always_comb begin
        rd_nxt = rd_idx + IDXW'(1);
        rd_lo  = '0;
        rd_hi  = '0;
        for (int i = 0; i < WIN; i++) begin
            if (rd_idx == IDXW'(i)) rd_lo = slot_q[i];
            if (rd_nxt == IDXW'(i)) rd_hi = slot_q[i];
        end
    end

endmodule

// File: rtl/dcfd_thresh.sv
// Threshold = floor(peak * fraction / 2^FSW), purely combinational.
module dcfd_thresh #(
    parameter int SW  = 8,
    parameter int FSW = 4
) (
    input  logic [SW-1:0]  peak,
    input  logic [FSW-1:0] frac,
    output logic [SW-1:0]  thr
);
    logic [SW+FSW-1:0] prod;

    always_comb begin
        prod = {{FSW{1'b0}}, peak} * {{SW{1'b0}}, frac};
        thr  = prod[SW+FSW-1:FSW];
    end

endmodule

// File: rtl/dcfd_frac_div.sv
// Restoring divider producing QW fractional bits of num/den, num <= den.
// A quotient of exactly one saturates to all ones; a zero divisor gives 0.
// Always takes QW steps after go so latency does not depend on the operands.
module dcfd_frac_div #(
    parameter int SW = 8,
    parameter int QW = 5,
    localparam int CW = $clog2(QW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [SW-1:0] num,
    input  logic [SW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          quo_valid
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] step;
        logic [SW:0]   rem;
        logic [SW-1:0] dvs;
        logic [QW-1:0] acc;
        logic [QW-1:0] res;
        logic          vld;
    } div_t;

    div_t r_q, r_d;

    logic [SW:0] rem_sh;
    logic        fits;
    logic [QW-1:0] acc_nx;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        rem_sh  = {r_q.rem[SW-1:0], 1'b0};
        fits    = (rem_sh >= {1'b0, r_q.dvs});
        acc_nx  = {r_q.acc[QW-2:0], fits};

        if (go) begin
            r_d.run  = 1'b1;
            r_d.step = '0;
            r_d.rem  = {1'b0, num};
            r_d.dvs  = den;
            r_d.acc  = '0;
        end else if (r_q.run) begin
            r_d.acc = acc_nx;
            r_d.rem = fits ? (rem_sh - {1'b0, r_q.dvs}) : rem_sh;
            if (r_q.step == CW'(QW - 1)) begin
                r_d.run = 1'b0;
                r_d.vld = 1'b1;
                r_d.res = (r_q.dvs == '0) ? '0 : acc_nx;
            end else begin
                r_d.step = r_q.step + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quo       = r_q.res;
    assign quo_valid = r_q.vld;

endmodule

// File: rtl/dcfd_ts_refine.sv
// Constant-fraction timestamp refiner: loads a window, finds the first pair
// of neighbours enclosing frac*peak, interpolates the crossing to 1/2^FRW.
module dcfd_ts_refine #(
    parameter int WIN = 16,
    parameter int SW  = 8,
    parameter int TSW = 24,
    parameter int FSW = 4,
    parameter int FRW = 5,
    localparam int IDXW = $clog2(WIN),
    localparam int OW   = TSW + FRW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TSW-1:0]  coarse_ts,
    input  logic [IDXW-1:0] trig_idx,
    input  logic [FSW-1:0]  frac_sel,
    input  logic            smp_valid,
    input  logic [SW-1:0]   smp_data,
    output logic            busy,
    output logic            done,
    output logic            invalid,
    output logic [OW-1:0]   fine_ts
);
    import dcfd_pkg::*;

    localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(WIN - 1);
    localparam logic [IDXW-1:0] LAST_PAIR = IDXW'(WIN - 2);

    typedef struct packed {
        phase_t          ph;
        logic [IDXW-1:0] widx;
        logic [IDXW-1:0] k;
        logic [SW-1:0]   peak;
        logic [TSW-1:0]  coarse;
        logic [IDXW-1:0] trig;
        logic [FSW-1:0]  fsel;
        logic            done;
        logic            inv;
        logic [OW-1:0]   fine;
    } ctl_t;

    ctl_t c_q, c_d;

    logic          buf_we;
    logic [SW-1:0] s_lo, s_hi;
    logic [SW-1:0] thr;
    logic          pair_hit;
    logic          div_go;
    logic [SW-1:0] div_num, div_den;
    logic [FRW-1:0] div_q;
    logic          div_v;
    logic [TSW-1:0] shifted;

    dcfd_sample_buf #(.WIN(WIN), .SW(SW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (buf_we),
        .wr_idx (c_q.widx),
        .wr_data(smp_data),
        .rd_idx (c_q.k),
        .rd_lo  (s_lo),
        .rd_hi  (s_hi)
    );

    dcfd_thresh #(.SW(SW), .FSW(FSW)) u_thr (
        .peak(c_q.peak),
        .frac(c_q.fsel),
        .thr (thr)
    );

    dcfd_frac_div #(.SW(SW), .QW(FRW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .num      (div_num),
        .den      (div_den),
        .quo      (div_q),
        .quo_valid(div_v)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        buf_we   = 1'b0;
        div_go   = 1'b0;

        pair_hit = (s_lo <= thr) && (s_hi >= thr);
        div_num  = thr - s_lo;
        div_den  = s_hi - s_lo;
        shifted  = c_q.coarse + TSW'(c_q.k) - TSW'(c_q.trig);

        unique case (c_q.ph)
            PH_IDLE: begin
                if (start) begin
                    c_d.ph     = PH_FILL;
                    c_d.widx   = '0;
                    c_d.peak   = '0;
                    c_d.coarse = coarse_ts;
                    c_d.trig   = trig_idx;
                    c_d.fsel   = frac_sel;
                end
            end
            PH_FILL: begin
                if (smp_valid) begin
                    buf_we = 1'b1;
                    if (smp_data > c_q.peak) c_d.peak = smp_data;
                    if (c_q.widx == LAST_SLOT) begin
                        c_d.ph = PH_SEEK;
                        c_d.k  = '0;
                    end else begin
                        c_d.widx = c_q.widx + IDXW'(1);
                    end
                end
            end
            PH_SEEK: begin
                if (pair_hit) begin
                    div_go = 1'b1;
                    c_d.ph = PH_DIVW;
                end else if (c_q.k == LAST_PAIR) begin
                    c_d.ph   = PH_IDLE;
                    c_d.done = 1'b1;
                    c_d.inv  = 1'b1;
                    c_d.fine = {c_q.coarse, {FRW{1'b0}}};
                end else begin
                    c_d.k = c_q.k + IDXW'(1);
                end
            end
            PH_DIVW: begin
                if (div_v) begin
                    c_d.ph   = PH_IDLE;
                    c_d.done = 1'b1;
                    c_d.inv  = 1'b0;
                    c_d.fine = {shifted, div_q};
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy    = (c_q.ph != PH_IDLE);
    assign done    = c_q.done;
    assign invalid = c_q.inv;
    assign fine_ts = c_q.fine;

endmodule

// File: rtl/dcfd_ts_refine_chk.sv
// Port-level properties of the refiner, attached by bind.
module dcfd_ts_refine_chk #(
    parameter int OW  = 29,
    parameter int FRW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          invalid,
    input logic [OW-1:0] fine_ts
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_MISS_NO_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (fine_ts[FRW-1:0] == '0)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fine_ts) |-> done); // R11

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(invalid) |-> done); // R11

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9

endmodule

bind dcfd_ts_refine dcfd_ts_refine_chk #(.OW(OW), .FRW(FRW)) u_chk (.*);

// File: tb/tb_dcfd_ts_refine.sv
`timescale 1ns/1ps
module tb_dcfd_ts_refine;
    localparam int WIN  = 16;
    localparam int SW   = 8;
    localparam int TSW  = 24;
    localparam int FSW  = 4;
    localparam int FRW  = 5;
    localparam int IDXW = 4;
    localparam int OW   = TSW + FRW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [TSW-1:0]  coarse_ts = '0;
    logic [IDXW-1:0] trig_idx = '0;
    logic [FSW-1:0]  frac_sel = '0;
    logic            smp_valid = 1'b0;
    logic [SW-1:0]   smp_data = '0;
    logic            busy, done, invalid;
    logic [OW-1:0]   fine_ts;

    always #10 clk = ~clk;

    dcfd_ts_refine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .coarse_ts(coarse_ts),
        .trig_idx(trig_idx), .frac_sel(frac_sel), .smp_valid(smp_valid),
        .smp_data(smp_data), .busy(busy), .done(done), .invalid(invalid),
        .fine_ts(fine_ts)
    );

    int n_vec = 0;
    int n_bad = 0;
    int smp [WIN];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference search: threshold, crossing index and fraction from the requirements
    task automatic model(input int fsel, output bit hit, output int k, output int frac, output bit zden);
        int pk, th, n, d;
        pk = 0;
        for (int i = 0; i < WIN; i++) if (smp[i] > pk) pk = smp[i];
        th = (pk * fsel) / 16;
        hit = 0; k = 0; frac = 0; zden = 0;
        for (int i = 0; i < WIN - 1; i++) begin
            if (!hit && smp[i] <= th && smp[i+1] >= th) begin
                hit = 1;
                k = i;
            end
        end
        if (hit) begin
            n = th - smp[k];
            d = smp[k+1] - smp[k];
            if (d == 0) begin
                zden = 1;
                frac = 0;
            end else begin
                frac = (n * 32) / d;
                if (frac > 31) frac = 31;
            end
        end
    endtask

    task automatic run_event(input logic [TSW-1:0] c, input int trig, input int fsel,
                             input bit gaps, input bit poke);
        bit hit, zden;
        int k, frac, lat, exp_lat;
        logic [TSW-1:0] exp_int;
        model(fsel, hit, k, frac, zden);
        if (poke) begin
            // R9: samples offered while idle must be dropped
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                smp_valid = 1'b1;
                smp_data  = 8'hFF;
            end
            @(negedge clk);
            smp_valid = 1'b0;
        end
        @(negedge clk);
        start = 1'b1; coarse_ts = c; trig_idx = IDXW'(trig); frac_sel = FSW'(fsel);
        @(negedge clk);
        start = 1'b0;
        coarse_ts = ~c; trig_idx = ~IDXW'(trig); frac_sel = ~FSW'(fsel); // R10
        chk(busy === 1'b1, "R9 busy after start", longint'(busy), 1);
        for (int i = 0; i < WIN; i++) begin
            if (gaps) begin
                int idle_n = int'($urandom % 3);
                for (int j = 0; j < idle_n; j++) begin
                    smp_valid = 1'b0;
                    @(negedge clk);
                end
            end
            smp_valid = 1'b1;
            smp_data  = SW'(smp[i]);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        lat = 0;
        while (done !== 1'b1 && lat < 64) begin
            if (poke && lat == 2) begin
                start = 1'b1; coarse_ts = TSW'($urandom); frac_sel = FSW'($urandom);
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        exp_lat = hit ? (k + 7) : (WIN - 1);
        chk(lat == exp_lat, "R8/R3 latency to done", lat, exp_lat);
        exp_int = hit ? TSW'(c + TSW'(k) - TSW'(trig)) : c;
        chk(fine_ts[OW-1:FRW] == exp_int, "R4 integer part", longint'(fine_ts[OW-1:FRW]), longint'(exp_int));
        if (!hit)
            chk(fine_ts[FRW-1:0] == 0, "R7 fraction on miss", longint'(fine_ts[FRW-1:0]), 0);
        else if (zden)
            chk(fine_ts[FRW-1:0] == FRW'(frac), "R6 equal pair fraction", longint'(fine_ts[FRW-1:0]), frac);
        else
            chk(fine_ts[FRW-1:0] == FRW'(frac), "R2/R5 fraction", longint'(fine_ts[FRW-1:0]), frac);
        chk(invalid === !hit, "R7 invalid flag", longint'(invalid), longint'(!hit));
        @(negedge clk);
        chk(done === 1'b0, "R8 done single cycle", longint'(done), 0);
        chk(busy === 1'b0, "R9 idle after result", longint'(busy), 0);
        chk(fine_ts[OW-1:FRW] == exp_int, "R11 result held", longint'(fine_ts[OW-1:FRW]), longint'(exp_int));
    endtask

    task automatic gen_random();
        int kind, base, rpos, step, pk, v;
        kind = int'($urandom % 4);
        base = int'($urandom % 20);
        rpos = int'($urandom % 10);
        step = 10 + int'($urandom % 70);
        pk   = 100 + int'($urandom % 156);
        for (int i = 0; i < WIN; i++) begin
            case (kind)
                0: begin
                    if (i < rpos) v = base + int'($urandom % 4);
                    else v = base + (i - rpos + 1) * step;
                    if (v > pk) v = pk;
                end
                1: v = int'($urandom % 256);
                2: v = base;
                default: v = 255 - i * (step / 8);
            endcase
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            smp[i] = v;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd61803));
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R1 in reset", longint'({done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R1 done", longint'(done), 0);
        chk(busy === 1'b0, "R1 busy", longint'(busy), 0);
        chk(invalid === 1'b0, "R1 invalid", longint'(invalid), 0);
        chk(fine_ts === '0, "R1 fine_ts", longint'(fine_ts), 0);

        // R6: all-zero window, threshold 0, equal pair at k=0
        for (int i = 0; i < WIN; i++) smp[i] = 0;
        run_event(24'h000100, 0, 8, 0, 0);
        // R7: threshold 0 below every sample, no crossing
        for (int i = 0; i < WIN; i++) smp[i] = 100;
        run_event(24'h123456, 3, 0, 0, 0);
        // R5: numerator equals denominator, saturates to 31
        for (int i = 0; i < WIN; i++) smp[i] = (i == 0) ? 0 : ((i == 1) ? 64 : 128);
        run_event(24'h000200, 1, 8, 0, 0);
        // R6: equal pair sitting on the threshold
        for (int i = 0; i < WIN; i++) smp[i] = (i < 2) ? 64 : 128;
        run_event(24'h000300, 0, 8, 1, 0);
        // R2/R5: linear ramp, fraction 5/16
        for (int i = 0; i < WIN; i++) smp[i] = i * 10;
        run_event(24'h000400, 2, 5, 0, 0);
        // R4: wrap upward and borrow downward
        run_event(24'hFFFFFE, 0, 12, 0, 0);
        for (int i = 0; i < WIN; i++) smp[i] = (i < 3) ? 2 : 200;
        run_event(24'h000001, 15, 8, 0, 0);
        // R9/R10: busy start and idle samples, full fraction
        for (int i = 0; i < WIN; i++) smp[i] = 5 + i * 7;
        run_event(24'h0ABCDE, 4, 15, 1, 1);

        for (int e = 0; e < 400; e++) begin
            gen_random();
            run_event(TSW'($urandom), int'($urandom % WIN), int'($urandom % 16),
                      bit'($urandom % 2), (e % 7) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule